// File: doc/BRIEF.md
# Category-Prioritized LRU Victim Selector

This block chooses which way of one set in an 8-way cache bank is to be replaced. It tracks a recency rank for every way together with a 2-bit tag that records how the line entered the bank. When a victim is requested, the block looks only at the two oldest ways. It evicts whichever of the two holds the less valuable category.

A static strap tells the block whether its bank sits next to a requesting core (local) or in the middle of the array (central). The strap selects one of two fixed category rankings. A single access port carries hits and fills. Hits refresh recency. Fills also install the category and mark the way valid.

Because only the two oldest positions are compared, lines in a highly ranked category still age out. They cannot take over the whole set. Until every way holds a line, an empty way is handed out first.

Top module: `cat_lru_victim_sel`

## Requirements
- R1: After reset every way is empty, way i holds recency rank i (0 = most recent, 7 = oldest), and `vic_valid` is low; the first victim request returns way 0 with `vic_empty` high.
- R2: Category codes are 0 = from off-chip memory, 1 = L1 write-back, 2 = promoted, 3 = demoted; with `bank_central` low the reported priority is 3 for code 1, 2 for code 2, 1 for code 0 and 0 for code 3.
- R3: With `bank_central` high the reported priority is 3 for code 2, 2 for code 0, 1 for code 3 and 0 for code 1.
- R4: An access (hit or fill) gives the accessed way rank 0; each way whose rank was below the accessed way's rank ages by one, and the other ways keep their rank.
- R5: A fill stores `acc_cat` for the way and marks it valid; a hit leaves the stored category unchanged, which is seen in `vic_cat` when that way is later evicted.
- R6: If any way is empty, the lowest-numbered empty way is the victim, with `vic_empty` high and `vic_cat` and `vic_prio` reported as 0; no category comparison is made.
- R7: With all ways valid, the ways at rank 7 and rank 6 are compared and the one with the lower priority is the victim; `vic_cat` and `vic_prio` describe the chosen way.
- R8: When the two compared ways have equal priority, the rank-7 way is the victim.
- R9: With all ways valid, a way at rank 5 or younger is never the victim, whatever its category.
- R10: `vic_valid` is high exactly in the cycle after a cycle with `vic_req` high. The result reflects the state before any access that is presented in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_central | input | 1 | Static: 0 = local bank ranking, 1 = central bank ranking |
| acc_valid | input | 1 | Access (hit or fill) this cycle |
| acc_way | input | 3 | Way being accessed |
| acc_fill | input | 1 | 1 = fill (install category, set valid), 0 = hit |
| acc_cat | input | 2 | Category of the line being filled |
| vic_req | input | 1 | Victim request |
| vic_valid | output | 1 | Victim result valid |
| vic_way | output | 3 | Chosen way |
| vic_cat | output | 2 | Category of the chosen way |
| vic_prio | output | 2 | Priority of the chosen way under the current ranking |
| vic_empty | output | 1 | Chosen way was empty |

## Verification
Recency and category state change on the clock edge that samples an access, and the first request that can see the change is the one in the following cycle. A victim result appears on the outputs one edge after its request and is computed from the state as it stood before that edge. The bench model applies each cycle's request against its pre-update state and then applies the access. It compares the outputs at the falling edge after the next rising edge, which is the cycle in which the registered result is due.

// File: rtl/cat_lru_pkg.sv
// Package: shared category encoding and the two fixed priority rankings.
// Assumes categories fit in 2 bits and priorities in 2 bits (3 = most valuable).
package cat_lru_pkg;

    localparam int CAT_W  = 2;
    localparam int PRIO_W = 2;

    typedef enum logic [CAT_W-1:0] {
        CAT_OFFCHIP  = 2'd0,
        CAT_L1WB     = 2'd1,
        CAT_PROMOTED = 2'd2,
        CAT_DEMOTED  = 2'd3
    } line_cat_e;

    // Map a category to its retention priority for a local or central bank.
    function automatic logic [PRIO_W-1:0] cat_prio(input logic [CAT_W-1:0] cat,
                                                   input logic            central);
        logic [PRIO_W-1:0] p;
        if (central) begin
            unique case (line_cat_e'(cat))
                CAT_PROMOTED: p = 2'd3;
                CAT_OFFCHIP:  p = 2'd2;
                CAT_DEMOTED:  p = 2'd1;
                default:      p = 2'd0;
            endcase
        end else begin
            unique case (line_cat_e'(cat))
                CAT_L1WB:     p = 2'd3;
                CAT_PROMOTED: p = 2'd2;
                CAT_OFFCHIP:  p = 2'd1;
                default:      p = 2'd0;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/cat_lru_rank_store.sv
// Module: per-way recency rank, valid bit and category storage for one set.
// Assumes WAYS is a power of two and ranks form a permutation of 0..WAYS-1,
// which reset establishes and every access preserves.
module cat_lru_rank_store
    import cat_lru_pkg::*;
#(
    parameter int WAYS   = 8,
    localparam int RANK_W = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         acc_valid,
    input  logic [RANK_W-1:0]            acc_way,
    input  logic                         acc_fill,
    input  logic [CAT_W-1:0]             acc_cat,
    output logic [WAYS-1:0][RANK_W-1:0]  rank_o,
    output logic [WAYS-1:0]              valid_o,
    output logic [WAYS-1:0][CAT_W-1:0]   cat_o
);

    logic [WAYS-1:0][RANK_W-1:0] rank_q;
    logic [WAYS-1:0]             valid_q;
    logic [WAYS-1:0][CAT_W-1:0]  cat_q;
    logic [RANK_W-1:0]           acc_rank;

    // Current rank of the accessed way, the aging threshold.
    always_comb begin
        acc_rank = rank_q[acc_way];
    end

    // Reset to distinct ranks; on access promote to MRU and age younger ways.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                rank_q[w]  <= RANK_W'(w);
                valid_q[w] <= 1'b0;
                cat_q[w]   <= '0;
            end
        end else if (acc_valid) begin
            for (int w = 0; w < WAYS; w++) begin
                if (acc_way == RANK_W'(w)) begin
                    rank_q[w] <= '0;
                    if (acc_fill) begin
                        valid_q[w] <= 1'b1;
                        cat_q[w]   <= acc_cat;
                    end
                end else if (rank_q[w] < acc_rank) begin
                    rank_q[w] <= rank_q[w] + RANK_W'(1);
                end
            end
        end
    end

    assign rank_o  = rank_q;
    assign valid_o = valid_q;
    assign cat_o   = cat_q;

endmodule

// File: rtl/cat_lru_prio_map.sv
// Module: translates each way's stored category to its priority.
// Assumes bank_central is static; purely combinational.
module cat_lru_prio_map
    import cat_lru_pkg::*;
#(
    parameter int WAYS = 8
) (
    input  logic                        central_i,
    input  logic [WAYS-1:0][CAT_W-1:0]  cat_i,
    output logic [WAYS-1:0][PRIO_W-1:0] prio_o
);

    // One priority lookup per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign prio_o[w] = cat_prio(cat_i[w], central_i);
    end

endmodule

// File: rtl/cat_lru_victim_pick.sv
// Module: chooses the victim way and registers the result.
// Assumes ranks are a permutation, so exactly one way sits at each of the
// two oldest ranks. Empty ways win before any category comparison.
module cat_lru_victim_pick
    import cat_lru_pkg::*;
#(
    parameter int WAYS   = 8,
    localparam int RANK_W = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         vic_req,
    input  logic [WAYS-1:0][RANK_W-1:0]  rank_i,
    input  logic [WAYS-1:0]              valid_i,
    input  logic [WAYS-1:0][CAT_W-1:0]   cat_i,
    input  logic [WAYS-1:0][PRIO_W-1:0]  prio_i,
    output logic                         vic_valid,
    output logic [RANK_W-1:0]            vic_way,
    output logic [CAT_W-1:0]             vic_cat,
    output logic [PRIO_W-1:0]            vic_prio,
    output logic                         vic_empty
);

    localparam logic [RANK_W-1:0] OLDEST_RANK = RANK_W'(WAYS - 1);
    localparam logic [RANK_W-1:0] NEXT_RANK   = RANK_W'(WAYS - 2);

    logic              empty_hit;
    logic [RANK_W-1:0] empty_way;
    logic [RANK_W-1:0] old_way;
    logic [RANK_W-1:0] next_way;
    logic [RANK_W-1:0] pick_way;

    // Lowest-numbered empty way, scanning downward so the lowest wins.
    always_comb begin
        empty_hit = 1'b0;
        empty_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                empty_hit = 1'b1;
                empty_way = RANK_W'(w);
            end
        end
    end

    // Locate the ways holding the two oldest ranks.
    always_comb begin
        old_way  = '0;
        next_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rank_i[w] == OLDEST_RANK) old_way  = RANK_W'(w);
            if (rank_i[w] == NEXT_RANK)   next_way = RANK_W'(w);
        end
    end

    // Evict the lower-priority candidate; a tie keeps the oldest way.
    always_comb begin
        if (prio_i[next_way] < prio_i[old_way]) pick_way = next_way;
        else                                     pick_way = old_way;
    end

    // Register the victim one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vic_valid <= 1'b0;
            vic_way   <= '0;
            vic_cat   <= '0;
            vic_prio  <= '0;
            vic_empty <= 1'b0;
        end else begin
            vic_valid <= vic_req;
            if (vic_req) begin
                if (empty_hit) begin
                    vic_way   <= empty_way;
                    vic_cat   <= '0;
                    vic_prio  <= '0;
                    vic_empty <= 1'b1;
                end else begin
                    vic_way   <= pick_way;
                    vic_cat   <= cat_i[pick_way];
                    vic_prio  <= prio_i[pick_way];
                    vic_empty <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/cat_lru_victim_sel.sv
// Module: top of the category-prioritized LRU victim selector for one set.
// Assumes bank_central is held constant during operation and that acc_way
// is below WAYS.
module cat_lru_victim_sel
    import cat_lru_pkg::*;
#(
    parameter int WAYS   = 8,
    localparam int RANK_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_central,
    input  logic              acc_valid,
    input  logic [RANK_W-1:0] acc_way,
    input  logic              acc_fill,
    input  logic [CAT_W-1:0]  acc_cat,
    input  logic              vic_req,
    output logic              vic_valid,
    output logic [RANK_W-1:0] vic_way,
    output logic [CAT_W-1:0]  vic_cat,
    output logic [PRIO_W-1:0] vic_prio,
    output logic              vic_empty
);

    logic [WAYS-1:0][RANK_W-1:0] rank_vec;
    logic [WAYS-1:0]             valid_vec;
    logic [WAYS-1:0][CAT_W-1:0]  cat_vec;
    logic [WAYS-1:0][PRIO_W-1:0] prio_vec;

    cat_lru_rank_store #(.WAYS(WAYS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_way   (acc_way),
        .acc_fill  (acc_fill),
        .acc_cat   (acc_cat),
        .rank_o    (rank_vec),
        .valid_o   (valid_vec),
        .cat_o     (cat_vec)
    );

    cat_lru_prio_map #(.WAYS(WAYS)) u_prio (
        .central_i (bank_central),
        .cat_i     (cat_vec),
        .prio_o    (prio_vec)
    );

    cat_lru_victim_pick #(.WAYS(WAYS)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .vic_req   (vic_req),
        .rank_i    (rank_vec),
        .valid_i   (valid_vec),
        .cat_i     (cat_vec),
        .prio_i    (prio_vec),
        .vic_valid (vic_valid),
        .vic_way   (vic_way),
        .vic_cat   (vic_cat),
        .vic_prio  (vic_prio),
        .vic_empty (vic_empty)
    );

endmodule

// File: rtl/cat_lru_victim_chk.sv
// Module: assertion checker bound to the selector top.
// Assumes it sees the stored ranks and valid bits of the top's rank store.
module cat_lru_victim_chk #(
    parameter int WAYS   = 8,
    localparam int RANK_W = $clog2(WAYS)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        acc_valid,
    input logic [RANK_W-1:0]           acc_way,
    input logic                        vic_req,
    input logic                        vic_valid,
    input logic [RANK_W-1:0]           vic_way,
    input logic                        vic_empty,
    input logic [WAYS-1:0][RANK_W-1:0] rank_vec,
    input logic [WAYS-1:0]             valid_vec
);

    localparam logic [RANK_W-1:0] NEXT_RANK = RANK_W'(WAYS - 2);

    logic [WAYS-1:0]             rank_seen;
    logic [WAYS-1:0][RANK_W-1:0] rank_d;
    logic [WAYS-1:0]             valid_d;
    logic [RANK_W-1:0]           acc_way_d;

    // Mark every rank value that some way holds.
    always_comb begin
        rank_seen = '0;
        for (int w = 0; w < WAYS; w++) rank_seen[rank_vec[w]] = 1'b1;
    end

    // Keep the previous cycle's state for comparison with the registered result.
    always_ff @(posedge clk) begin
        rank_d    <= rank_vec;
        valid_d   <= valid_vec;
        acc_way_d <= acc_way;
    end

    AST_RANK_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n) &rank_seen); // R4
    AST_ACCESS_TO_MRU: assert property (@(posedge clk) disable iff (!rst_n) acc_valid |=> (rank_vec[acc_way_d] == '0)); // R4
    AST_VICTIM_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) vic_req |=> vic_valid); // R10
    AST_VICTIM_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !vic_req |=> !vic_valid); // R10
    AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (vic_valid && !vic_empty) |-> (&valid_d)); // R6
    AST_EMPTY_TARGET: assert property (@(posedge clk) disable iff (!rst_n) (vic_valid && vic_empty) |-> !valid_d[vic_way]); // R6
    AST_OLDEST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) (vic_valid && !vic_empty) |-> (rank_d[vic_way] >= NEXT_RANK)); // R9

endmodule

bind cat_lru_victim_sel cat_lru_victim_chk #(.WAYS(WAYS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_way   (acc_way),
    .vic_req   (vic_req),
    .vic_valid (vic_valid),
    .vic_way   (vic_way),
    .vic_empty (vic_empty),
    .rank_vec  (rank_vec),
    .valid_vec (valid_vec)
);

// File: tb/tb_cat_lru_victim_sel.sv
module tb_cat_lru_victim_sel;

    localparam int CLK_PERIOD = 10;
    localparam int WAYS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bank_central = 1'b0;
    logic       acc_valid = 1'b0;
    logic [2:0] acc_way = '0;
    logic       acc_fill = 1'b0;
    logic [1:0] acc_cat = '0;
    logic       vic_req = 1'b0;
    logic       vic_valid;
    logic [2:0] vic_way;
    logic [1:0] vic_cat;
    logic [1:0] vic_prio;
    logic       vic_empty;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // Behavioural reference state
    int m_rank [WAYS];
    bit m_valid [WAYS];
    int m_cat [WAYS];
    bit e_valid;
    int e_way, e_cat, e_prio;
    bit e_empty;

    cat_lru_victim_sel dut (
        .clk(clk), .rst_n(rst_n), .bank_central(bank_central),
        .acc_valid(acc_valid), .acc_way(acc_way), .acc_fill(acc_fill), .acc_cat(acc_cat),
        .vic_req(vic_req), .vic_valid(vic_valid), .vic_way(vic_way),
        .vic_cat(vic_cat), .vic_prio(vic_prio), .vic_empty(vic_empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R2/R3 ranking tables written from the requirements
    function automatic int ref_prio(input int cat, input bit central);
        if (central) begin
            case (cat)
                2: return 3;
                0: return 2;
                3: return 1;
                default: return 0;
            endcase
        end
        case (cat)
            1: return 3;
            2: return 2;
            0: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        for (int w = 0; w < WAYS; w++) begin
            m_rank[w] = w; m_valid[w] = 0; m_cat[w] = 0;
        end
        e_valid = 0;
    endtask

    // Request is judged on the pre-access state, then the access is applied.
    task automatic model_step();
        e_valid = vic_req;
        if (vic_req) begin
            int found = -1;
            for (int w = WAYS - 1; w >= 0; w--) if (!m_valid[w]) found = w;
            if (found >= 0) begin
                e_way = found; e_empty = 1; e_cat = 0; e_prio = 0;
            end else begin
                int old_w = 0, nxt_w = 0;
                for (int w = 0; w < WAYS; w++) begin
                    if (m_rank[w] == WAYS - 1) old_w = w;
                    if (m_rank[w] == WAYS - 2) nxt_w = w;
                end
                if (ref_prio(m_cat[nxt_w], bank_central) < ref_prio(m_cat[old_w], bank_central))
                    e_way = nxt_w;
                else
                    e_way = old_w;
                e_empty = 0; e_cat = m_cat[e_way]; e_prio = ref_prio(e_cat, bank_central);
            end
        end
        if (acc_valid) begin
            int a = int'(acc_way);
            int ar = m_rank[a];
            for (int w = 0; w < WAYS; w++) begin
                if (w == a) m_rank[w] = 0;
                else if (m_rank[w] < ar) m_rank[w]++;
            end
            if (acc_fill) begin m_valid[a] = 1; m_cat[a] = int'(acc_cat); end
        end
    endtask

    // One clock: update model, pass the edge, compare at the falling edge.
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(vic_valid === e_valid, "R10", int'(vic_valid), int'(e_valid));
        if (e_valid) begin
            chk(vic_way === 3'(e_way), e_empty ? "R6" : "R7", int'(vic_way), e_way);
            chk(vic_empty === e_empty, "R6", int'(vic_empty), int'(e_empty));
            chk(vic_cat === 2'(e_cat), "R5", int'(vic_cat), e_cat);
            chk(vic_prio === 2'(e_prio), bank_central ? "R3" : "R2", int'(vic_prio), e_prio);
        end
    endtask

    task automatic do_reset(input bit central);
        rst_n = 0; acc_valid = 0; vic_req = 0; bank_central = central;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic access(input int way, input bit fill, input int cat);
        acc_valid = 1; acc_way = 3'(way); acc_fill = fill; acc_cat = 2'(cat);
        tick();
        acc_valid = 0; acc_fill = 0;
    endtask

    task automatic request(input int exp_way, input string req);
        vic_req = 1;
        tick();
        vic_req = 0;
        chk(vic_way === 3'(exp_way), req, int'(vic_way), exp_way);
    endtask

    // Fill all ways in order 0..7: way k ends at rank 7-k.
    task automatic fill_all(input int c0, input int c1, input int c2, input int rest);
        access(0, 1, c0);
        access(1, 1, c1);
        access(2, 1, c2);
        for (int w = 3; w < WAYS; w++) access(w, 1, rest);
    endtask

    initial begin
        // R1: reset state
        do_reset(0);
        chk(vic_valid === 1'b0, "R1", int'(vic_valid), 0);
        request(0, "R1");
        chk(vic_empty === 1'b1, "R1", int'(vic_empty), 1);

        // R6: lowest empty way after partial fill
        for (int w = 0; w < 4; w++) access(w, 1, 2);
        request(4, "R6");
        chk(vic_empty === 1'b1, "R6", int'(vic_empty), 1);

        // Local ranking: way0 L1WB r7, way1 offchip r6, way2 demoted r5
        do_reset(0);
        fill_all(1, 0, 3, 2);
        request(1, "R9");                       // demoted way2 outside window
        chk(vic_prio === 2'd1, "R2", int'(vic_prio), 1);
        access(1, 0, 3);                        // hit way1, category must stay offchip
        request(2, "R4");                       // window now way0 / way2
        chk(vic_cat === 2'd3, "R5", int'(vic_cat), 3);
        access(0, 0, 0);
        for (int w = 2; w < WAYS; w++) access(w, 0, 0);
        request(1, "R7");                       // window way1 / way0
        chk(vic_cat === 2'd0, "R5", int'(vic_cat), 0);

        // R8: tie picks oldest way
        do_reset(0);
        fill_all(2, 2, 2, 2);
        request(0, "R8");

        // R3: central ranking reverses the local outcome
        do_reset(1);
        fill_all(1, 0, 2, 2);
        request(0, "R3");
        chk(vic_prio === 2'd0, "R3", int'(vic_prio), 0);

        // R10: request and access in the same cycle sees the old state
        vic_req = 1; acc_valid = 1; acc_way = 3'd0; acc_fill = 0;
        tick();
        vic_req = 0; acc_valid = 0;
        chk(vic_way === 3'd0, "R10", int'(vic_way), 0);
        request(1, "R10");

        // Mixed traffic against the model, both rankings
        for (int pass = 0; pass < 2; pass++) begin
            do_reset(pass[0]);
            for (int i = 0; i < 600; i++) begin
                acc_valid = ($urandom_range(0, 3) != 0);
                acc_way = 3'($urandom_range(0, 7));
                acc_fill = ($urandom_range(0, 1) == 1);
                acc_cat = 2'($urandom_range(0, 3));
                vic_req = ($urandom_range(0, 2) == 0);
                tick();
            end
            acc_valid = 0; vic_req = 0;
            tick();
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule